// File: doc/BRIEF.md
# Descriptor Ownership Process Controller

This block sequences one direction (transmit or receive) of a descriptor-list packet DMA. Once started, it reads the first word of the descriptor at its current list pointer and looks at the ownership bit. A descriptor held by the DMA leads the block to wait for packet data, run the data transfer, optionally write a timestamp, and then close the descriptor. Closing writes frame status with the ownership bit cleared, which returns the descriptor to the host. A descriptor held by the host puts the block into a suspended state, where it waits for a resume trigger.

Bus protocol handling and data movement belong to surrounding logic. That logic talks to this block through simple request/acknowledge handshakes for descriptor reads, descriptor writes and data transfers. The block exports a fixed 3-bit process-state code and single-cycle event pulses that feed a status register. One parameter selects the transmit or receive resume rules. Transmit frames are checked against an oversize (jabber) limit, and an error response on any handshake latches a fatal condition that only reset can clear.

Top module: `dma_own_fsm`

## Requirements
- R1: `proc_state` is encoded 000 stopped, 001 fetching descriptor, 011 waiting for packet, 100 suspended, 101 closing descriptor, 110 timestamp write, 111 transferring data. Code 010 never appears. After the synchronous reset the state is 000 and no request is active.
- R2: From 000, `cmd_start` moves the block to 001 and loads `desc_addr` from `list_base`. From any state, `cmd_stop` forces 000 and pulses `ev_stopped`. If the state was already 000 there is no pulse.
- R3: In 001, a completed read whose ownership bit `desc_own` is 0 moves the block to 100 without advancing `desc_addr`. In transmit mode it pulses `ev_unavail` on every such miss.
- R4: In receive mode, `ev_unavail` pulses on a miss only if the previously fetched descriptor had ownership bit 1, or if the miss is the first fetch after a start.
- R5: Transmit mode leaves 100 only on `poll_demand`. Receive mode leaves 100 on `poll_demand` or on `pkt_ready` (an incoming frame). Both resume to 001.
- R6: A fetched descriptor with ownership bit 1 leads to 011. `pkt_ready` then leads to 111. `xfer_done` leads to 110 if `stamp_en` is set and no error is flagged, and to 101 otherwise. 110 goes to 101 on `desc_wr_ack`. In 101 the write data has bit 31 = 0. Its acknowledge pulses `ev_complete`, adds the stride (default 16) to `desc_addr` and returns to 001.
- R7: In transmit mode, `xfer_len` above 2048, or above 10240 when `jumbo_en` is set, at `xfer_done` pulses `ev_jabber`. The close then writes status bit 14 = 1 and, on acknowledge, goes to 000 with `ev_stopped` and no `ev_complete`.
- R8: In transmit mode, `xfer_underrun` at `xfer_done`, with no jabber, pulses `ev_underrun`. The close then writes status bit 1 = 1 and, on acknowledge, goes to 100 with `desc_addr` advanced.
- R9: An error input during its own active request pulses `ev_fatal`, forces 000 and sets `fatal`. Once `fatal` is set, all requests stay low and `cmd_start` is ignored until reset.
- R10: `proc_state` and all event outputs are registered. They change on the clock edge that samples the causing condition, and each event lasts exactly one cycle.
- R11: A `cmd_stop` in the same cycle as a handshake acknowledge wins. The block goes to 000 and raises no event belonging to that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start command (acts in stopped state) |
| cmd_stop | input | 1 | Stop command |
| poll_demand | input | 1 | Poll-demand pulse |
| pkt_ready | input | 1 | Transmit: packet queued; receive: recognised frame arriving |
| jumbo_en | input | 1 | Raises the jabber limit to the jumbo size |
| stamp_en | input | 1 | Request a timestamp write for this frame |
| list_base | input | ADDR_W | Descriptor list base, loaded on start |
| desc_rd_req | output | 1 | Descriptor read request |
| desc_addr | output | ADDR_W | Current descriptor address |
| desc_rd_ack | input | 1 | Descriptor read complete |
| desc_rd_err | input | 1 | Descriptor read error response |
| desc_own | input | 1 | Bit 31 of the first descriptor word returned by the read |
| xfer_req | output | 1 | Data transfer request |
| xfer_done | input | 1 | Data transfer finished |
| xfer_err | input | 1 | Data transfer error response |
| xfer_underrun | input | 1 | Transmit data ran dry during the frame |
| xfer_len | input | LEN_W | Frame length in bytes, valid with `xfer_done` |
| desc_wr_req | output | 1 | Descriptor write request |
| desc_wr_stamp | output | 1 | The current write is the timestamp write |
| desc_wr_data | output | 32 | Status word for the close write |
| desc_wr_ack | input | 1 | Descriptor write complete |
| desc_wr_err | input | 1 | Descriptor write error response |
| proc_state | output | 3 | Process-state code |
| ev_complete | output | 1 | Frame closed normally |
| ev_unavail | output | 1 | Host-owned descriptor found |
| ev_stopped | output | 1 | Process entered stopped |
| ev_jabber | output | 1 | Transmit frame over the size limit |
| ev_underrun | output | 1 | Transmit underrun reported |
| ev_fatal | output | 1 | Bus error seen |
| fatal | output | 1 | Sticky fatal condition |

## Verification
The functions that can collide are the stop command and the completion of a handshake. A stop can arrive in the same cycle as a descriptor-read acknowledge or a transfer-done, and each path would pick a different next state and event. The bench drives both inputs on one clock edge, in the fetch state and in the transfer state. It expects state 000 with `ev_stopped` set and with neither `ev_unavail` nor `ev_complete`, and it then restarts from a new base to confirm that the pointer reloads cleanly.

// File: rtl/dma_own_pkg.sv
package dma_own_pkg;
  // Process-state codes are visible to software; values are fixed.
  typedef enum logic [2:0] {
    PS_STOP  = 3'b000,
    PS_FETCH = 3'b001,
    PS_WAIT  = 3'b011,
    PS_SUSP  = 3'b100,
    PS_CLOSE = 3'b101,
    PS_STAMP = 3'b110,
    PS_MOVE  = 3'b111
  } proc_st_e;

  localparam int STAT_W  = 32;
  localparam int JAB_BIT = 14;
  localparam int UF_BIT  = 1;
endpackage

// File: rtl/dma_desc_ptr.sv
module dma_desc_ptr #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= addr + STEP;
  end
endmodule

// File: rtl/dma_jabber_chk.sv
module dma_jabber_chk #(
  parameter int LEN_W       = 14,
  parameter int STD_LIMIT   = 2048,
  parameter int JUMBO_LIMIT = 10240
) (
  input  logic [LEN_W-1:0] len,
  input  logic             jumbo,
  output logic             over
);
  localparam logic [LEN_W:0] LIM_S = (LEN_W+1)'(STD_LIMIT);
  localparam logic [LEN_W:0] LIM_J = (LEN_W+1)'(JUMBO_LIMIT);

  assign over = {1'b0, len} > (jumbo ? LIM_J : LIM_S);
endmodule

// File: rtl/dma_own_fsm.sv
module dma_own_fsm
  import dma_own_pkg::*;
#(
  parameter bit IS_RX       = 1'b0,
  parameter int ADDR_W      = 32,
  parameter int DESC_STRIDE = 16,
  parameter int LEN_W       = 14,
  parameter int STD_LIMIT   = 2048,
  parameter int JUMBO_LIMIT = 10240
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              poll_demand,
  input  logic              pkt_ready,
  input  logic              jumbo_en,
  input  logic              stamp_en,
  input  logic [ADDR_W-1:0] list_base,
  output logic              desc_rd_req,
  output logic [ADDR_W-1:0] desc_addr,
  input  logic              desc_rd_ack,
  input  logic              desc_rd_err,
  input  logic              desc_own,
  output logic              xfer_req,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic              xfer_underrun,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              desc_wr_req,
  output logic              desc_wr_stamp,
  output logic [STAT_W-1:0] desc_wr_data,
  input  logic              desc_wr_ack,
  input  logic              desc_wr_err,
  output logic [2:0]        proc_state,
  output logic              ev_complete,
  output logic              ev_unavail,
  output logic              ev_stopped,
  output logic              ev_jabber,
  output logic              ev_underrun,
  output logic              ev_fatal,
  output logic              fatal
);
  proc_st_e st, st_n;
  logic fatal_q, prev_own_q, jab_q, uf_q;
  logic over, jab_hit, uf_hit;
  logic ptr_load, ptr_adv;
  logic bus_err, rd_ok, done_ok, wr_ok;
  logic n_cmp, n_una, n_stp, n_jab, n_uf, n_fat;

  dma_desc_ptr #(.ADDR_W(ADDR_W), .STRIDE(DESC_STRIDE)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(list_base),
    .adv(ptr_adv), .addr(desc_addr)
  );

  dma_jabber_chk #(.LEN_W(LEN_W), .STD_LIMIT(STD_LIMIT),
                   .JUMBO_LIMIT(JUMBO_LIMIT)) u_jab (
    .len(xfer_len), .jumbo(jumbo_en), .over(over)
  );

  // Oversize and underrun checks apply only to the transmit direction.
  generate
    if (IS_RX) begin : g_rx
      assign jab_hit = 1'b0;
      assign uf_hit  = 1'b0;
    end else begin : g_tx
      assign jab_hit = over;
      assign uf_hit  = xfer_underrun & ~over;
    end
  endgenerate

  assign desc_rd_req   = (st == PS_FETCH) & ~fatal_q;
  assign xfer_req      = (st == PS_MOVE)  & ~fatal_q;
  assign desc_wr_req   = ((st == PS_CLOSE) | (st == PS_STAMP)) & ~fatal_q;
  assign desc_wr_stamp = (st == PS_STAMP);
  always_comb begin
    desc_wr_data = '0;
    if (st == PS_CLOSE) begin
      desc_wr_data[JAB_BIT] = jab_q;
      desc_wr_data[UF_BIT]  = uf_q;
    end
  end

  assign bus_err = (desc_rd_req & desc_rd_err) | (xfer_req & xfer_err)
                 | (desc_wr_req & desc_wr_err);
  assign rd_ok   = desc_rd_req & desc_rd_ack;
  assign done_ok = xfer_req & xfer_done;
  assign wr_ok   = desc_wr_req & desc_wr_ack;

  always_comb begin
    st_n = st;
    ptr_load = 1'b0; ptr_adv = 1'b0;
    n_cmp = 1'b0; n_una = 1'b0; n_stp = 1'b0;
    n_jab = 1'b0; n_uf  = 1'b0; n_fat = 1'b0;
    if (bus_err) begin
      st_n = PS_STOP; n_fat = 1'b1; n_stp = 1'b1;
    end else if (cmd_stop) begin
      st_n = PS_STOP; n_stp = (st != PS_STOP);
    end else begin
      unique case (st)
        PS_STOP:
          if (cmd_start && !fatal_q) begin
            st_n = PS_FETCH; ptr_load = 1'b1;
          end
        PS_FETCH:
          if (rd_ok) begin
            if (desc_own) st_n = PS_WAIT;
            else begin
              st_n  = PS_SUSP;
              n_una = IS_RX ? prev_own_q : 1'b1;
            end
          end
        PS_WAIT:
          if (pkt_ready) st_n = PS_MOVE;
        PS_MOVE:
          if (done_ok) begin
            st_n  = (stamp_en && !jab_hit && !uf_hit) ? PS_STAMP : PS_CLOSE;
            n_jab = jab_hit;
            n_uf  = uf_hit;
          end
        PS_STAMP:
          if (wr_ok) st_n = PS_CLOSE;
        PS_CLOSE:
          if (wr_ok) begin
            ptr_adv = 1'b1;
            if (jab_q) begin
              st_n = PS_STOP; n_stp = 1'b1;
            end else if (uf_q) begin
              st_n = PS_SUSP;
            end else begin
              st_n = PS_FETCH; n_cmp = 1'b1;
            end
          end
        PS_SUSP:
          if (poll_demand || (IS_RX && pkt_ready)) st_n = PS_FETCH;
        default: st_n = PS_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PS_STOP;
      fatal_q <= 1'b0; prev_own_q <= 1'b1; jab_q <= 1'b0; uf_q <= 1'b0;
      {ev_complete, ev_unavail, ev_stopped, ev_jabber, ev_underrun, ev_fatal} <= '0;
    end else begin
      st <= st_n;
      if (n_fat)    fatal_q <= 1'b1;
      if (ptr_load) prev_own_q <= 1'b1;
      else if (rd_ok && !cmd_stop && !bus_err) prev_own_q <= desc_own;
      if (done_ok && !cmd_stop && !bus_err) begin
        jab_q <= jab_hit; uf_q <= uf_hit;
      end
      ev_complete <= n_cmp; ev_unavail  <= n_una; ev_stopped <= n_stp;
      ev_jabber   <= n_jab; ev_underrun <= n_uf;  ev_fatal   <= n_fat;
    end
  end

  assign proc_state = st;
  assign fatal      = fatal_q;
endmodule

// File: rtl/dma_own_fsm_chk.sv
module dma_own_fsm_chk #(
  parameter bit IS_RX = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_stop,
  input logic       poll_demand,
  input logic       pkt_ready,
  input logic       desc_rd_req,
  input logic       desc_rd_ack,
  input logic       desc_rd_err,
  input logic       desc_own,
  input logic       desc_wr_req,
  input logic       desc_wr_stamp,
  input logic       desc_wr_own,
  input logic       xfer_req,
  input logic       fatal,
  input logic [2:0] proc_state
);
  // R1: the reserved code is never produced
  p_no_reserved_r1: assert property (@(posedge clk) disable iff (rst)
    proc_state != 3'b010);

  // R2: a stop lands in the stopped code on the next cycle
  p_stop_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> proc_state == 3'b000);

  // R3: a host-owned descriptor suspends the process
  p_miss_suspend_r3: assert property (@(posedge clk) disable iff (rst)
    (desc_rd_req && desc_rd_ack && !desc_rd_err && !desc_own && !cmd_stop)
      |=> proc_state == 3'b100);

  // R5: without a resume trigger the suspended state holds
  p_hold_suspend_r5: assert property (@(posedge clk) disable iff (rst)
    (proc_state == 3'b100 && !poll_demand && !cmd_stop && !(IS_RX && pkt_ready))
      |=> proc_state == 3'b100);

  // R6: the close write hands the descriptor back to the host
  p_close_own_r6: assert property (@(posedge clk) disable iff (rst)
    (desc_wr_req && !desc_wr_stamp) |-> !desc_wr_own);

  // R9: after a bus error no request is issued
  p_fatal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    fatal |-> (!desc_rd_req && !desc_wr_req && !xfer_req));

  // R9: the fatal condition persists until reset
  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);
endmodule

bind dma_own_fsm dma_own_fsm_chk #(.IS_RX(IS_RX)) u_chk (
  .clk(clk), .rst(rst), .cmd_stop(cmd_stop), .poll_demand(poll_demand),
  .pkt_ready(pkt_ready), .desc_rd_req(desc_rd_req), .desc_rd_ack(desc_rd_ack),
  .desc_rd_err(desc_rd_err), .desc_own(desc_own), .desc_wr_req(desc_wr_req),
  .desc_wr_stamp(desc_wr_stamp), .desc_wr_own(desc_wr_data[31]),
  .xfer_req(xfer_req), .fatal(fatal), .proc_state(proc_state)
);

// File: tb/tb_dma_own_fsm.sv
`timescale 1ns/100ps
module tb_dma_own_fsm;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // index 0: transmit instance, index 1: receive instance
  logic        start [2], stop [2], poll [2], pkt [2], jumbo [2], stamp [2];
  logic        rd_ack [2], rd_err [2], own [2], xdone [2], xerr [2], xuf [2];
  logic        wr_ack [2], wr_err [2];
  logic [31:0] base [2];
  logic [13:0] xlen [2];
  logic        rd_req [2], xreq [2], wr_req [2], wr_stamp [2];
  logic        e_cmp [2], e_un [2], e_stp [2], e_jab [2], e_uf [2], e_fat [2], fat [2];
  logic [31:0] daddr [2], wdata [2];
  logic [2:0]  pst [2];

  for (genvar gi = 0; gi < 2; gi++) begin : g_d
    dma_own_fsm #(.IS_RX(gi != 0)) dut (
      .clk(clk), .rst(rst), .cmd_start(start[gi]), .cmd_stop(stop[gi]),
      .poll_demand(poll[gi]), .pkt_ready(pkt[gi]), .jumbo_en(jumbo[gi]),
      .stamp_en(stamp[gi]), .list_base(base[gi]), .desc_rd_req(rd_req[gi]),
      .desc_addr(daddr[gi]), .desc_rd_ack(rd_ack[gi]), .desc_rd_err(rd_err[gi]),
      .desc_own(own[gi]), .xfer_req(xreq[gi]), .xfer_done(xdone[gi]),
      .xfer_err(xerr[gi]), .xfer_underrun(xuf[gi]), .xfer_len(xlen[gi]),
      .desc_wr_req(wr_req[gi]), .desc_wr_stamp(wr_stamp[gi]),
      .desc_wr_data(wdata[gi]), .desc_wr_ack(wr_ack[gi]), .desc_wr_err(wr_err[gi]),
      .proc_state(pst[gi]), .ev_complete(e_cmp[gi]), .ev_unavail(e_un[gi]),
      .ev_stopped(e_stp[gi]), .ev_jabber(e_jab[gi]), .ev_underrun(e_uf[gi]),
      .ev_fatal(e_fat[gi]), .fatal(fat[gi])
    );
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] tx_addr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr(int d);
    start[d] = 0; stop[d] = 0; poll[d] = 0; pkt[d] = 0; jumbo[d] = 0;
    stamp[d] = 0; rd_ack[d] = 0; rd_err[d] = 0; own[d] = 0; xdone[d] = 0;
    xerr[d] = 0; xuf[d] = 0; wr_ack[d] = 0; wr_err[d] = 0; xlen[d] = '0;
  endtask

  task automatic cyc(int d);
    @(negedge clk);
    clr(d);
  endtask

  function automatic bit exp_jab(int len, bit jm);
    return len > (jm ? 10240 : 2048);
  endfunction

  // Runs one transmit frame from the fetch state and checks every step.
  task automatic tx_frame(int len, bit jm, bit ufi, bit ts);
    bit jb = exp_jab(len, jm);
    bit uf = ufi && !jb;
    rd_ack[0] = 1; own[0] = 1; cyc(0);
    chk("R6 owned->wait", pst[0], 3);
    pkt[0] = 1; cyc(0);
    chk("R6 wait->move", pst[0], 7);
    xlen[0] = 14'(len); jumbo[0] = jm; xuf[0] = ufi; stamp[0] = ts; xdone[0] = 1; cyc(0);
    chk("R7 jabber event", e_jab[0], jb);
    chk("R8 underrun event", e_uf[0], uf);
    chk("R6 done->stamp/close", pst[0], (ts && !jb && !uf) ? 6 : 5);
    if (pst[0] == 6) begin
      chk("R6 stamp write flag", wr_stamp[0], 1);
      wr_ack[0] = 1; cyc(0);
      chk("R6 stamp->close", pst[0], 5);
    end
    chk("R7 R8 close status word", wdata[0], (32'(jb) << 14) | (32'(uf) << 1));
    wr_ack[0] = 1; cyc(0);
    chk("R6 close next state", pst[0], jb ? 0 : (uf ? 4 : 1));
    chk("R7 stopped event", e_stp[0], jb);
    chk("R6 complete event", e_cmp[0], !jb && !uf);
    tx_addr = tx_addr + 16;
    chk("R6 pointer stride", daddr[0], tx_addr);
    if (pst[0] == 0) begin
      base[0] = tx_addr; start[0] = 1; cyc(0);
      chk("R2 restart", pst[0], 1);
    end else if (pst[0] == 4) begin
      poll[0] = 1; cyc(0);
      chk("R8 poll after underrun", pst[0], 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit prev;
    clr(0); clr(1); base[0] = '0; base[1] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset state tx", pst[0], 0);
    chk("R1 reset state rx", pst[1], 0);
    chk("R1 no request at reset", rd_req[0] | xreq[0] | wr_req[0], 0);

    // ---------------- transmit directed ----------------
    base[0] = 32'h1000; start[0] = 1; cyc(0);
    chk("R2 start->fetch", pst[0], 1);
    chk("R2 base loaded", daddr[0], 32'h1000);
    rd_ack[0] = 1; own[0] = 0; cyc(0);
    chk("R3 miss->suspend", pst[0], 4);
    chk("R3 unavail pulse", e_un[0], 1);
    chk("R3 pointer held", daddr[0], 32'h1000);
    pkt[0] = 1;
    chk("R10 no change before edge", pst[0], 4);
    cyc(0);
    chk("R10 pulse one cycle", e_un[0], 0);
    chk("R5 tx ignores frame arrival", pst[0], 4);
    poll[0] = 1; cyc(0);
    chk("R5 tx poll resumes", pst[0], 1);
    rd_ack[0] = 1; own[0] = 0; cyc(0);
    chk("R3 tx repeats unavail", e_un[0], 1);
    poll[0] = 1; cyc(0);
    tx_addr = 32'h1000;
    tx_frame(100, 0, 0, 1);
    // length corners and underrun directed
    tx_frame(2048, 0, 0, 0);
    tx_frame(2049, 0, 0, 0);
    tx_frame(10240, 1, 0, 0);
    tx_frame(10241, 1, 1, 1);
    tx_frame(500, 0, 1, 1);
    for (int i = 0; i < 40; i++)
      tx_frame($urandom_range(0, 12000), 1'($urandom), ($urandom % 4) == 0, 1'($urandom));

    // R11: stop together with a read acknowledge
    rd_ack[0] = 1; own[0] = 0; stop[0] = 1; cyc(0);
    chk("R11 stop beats read ack", pst[0], 0);
    chk("R11 no unavail on stop", e_un[0], 0);
    chk("R2 stop event", e_stp[0], 1);
    stop[0] = 1; cyc(0);
    chk("R2 no event when already stopped", e_stp[0], 0);
    base[0] = 32'h2000; start[0] = 1; cyc(0);
    chk("R11 reload after stop", daddr[0], 32'h2000);
    rd_ack[0] = 1; own[0] = 1; cyc(0);
    pkt[0] = 1; cyc(0);
    xdone[0] = 1; xlen[0] = 14'd60; stop[0] = 1; cyc(0);
    chk("R11 stop beats transfer done", pst[0], 0);
    chk("R11 no complete on stop", e_cmp[0], 0);

    // ---------------- receive directed ----------------
    base[1] = 32'h4000; start[1] = 1; cyc(1);
    chk("R2 rx start", pst[1], 1);
    rd_ack[1] = 1; own[1] = 0; cyc(1);
    chk("R4 first miss pulses", e_un[1], 1);
    pkt[1] = 1; cyc(1);
    chk("R5 rx frame resumes", pst[1], 1);
    rd_ack[1] = 1; own[1] = 0; cyc(1);
    chk("R4 back-to-back miss silent", e_un[1], 0);
    chk("R3 rx miss suspends", pst[1], 4);
    poll[1] = 1; cyc(1);
    chk("R5 rx poll resumes", pst[1], 1);
    prev = 0;
    for (int i = 0; i < 40; i++) begin
      bit o = 1'($urandom);
      rd_ack[1] = 1; own[1] = o; cyc(1);
      chk("R4 rx unavail rule", e_un[1], !o && prev);
      chk("R3 R6 rx fetch result", pst[1], o ? 3 : 4);
      prev = o;
      if (o) begin
        pkt[1] = 1; cyc(1);
        xdone[1] = 1; xlen[1] = 14'($urandom_range(0, 12000)); xuf[1] = 1; cyc(1);
        chk("R7 rx has no jabber", e_jab[1], 0);
        chk("R6 rx close", pst[1], 5);
        wr_ack[1] = 1; cyc(1);
        chk("R6 rx stays running", pst[1], 1);
        chk("R6 rx complete", e_cmp[1], 1);
      end else begin
        if ($urandom % 2) poll[1] = 1; else pkt[1] = 1;
        cyc(1);
        chk("R5 rx resume", pst[1], 1);
      end
    end

    // ---------------- fatal error ----------------
    base[0] = 32'h3000; start[0] = 1; cyc(0);
    rd_ack[0] = 1; own[0] = 1; cyc(0);
    pkt[0] = 1; cyc(0);
    xdone[0] = 1; xerr[0] = 1; cyc(0);
    chk("R9 fatal stops", pst[0], 0);
    chk("R9 fatal event", e_fat[0], 1);
    chk("R9 fatal level", fat[0], 1);
    start[0] = 1; cyc(0);
    chk("R9 start ignored", pst[0], 0);
    chk("R9 no request", rd_req[0], 0);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk("R9 reset clears fatal", fat[0], 0);
    base[0] = 32'h3000; start[0] = 1; cyc(0);
    rd_ack[0] = 1; rd_err[0] = 1; cyc(0);
    chk("R9 read error fatal", fat[0], 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule